// File: doc/BRIEF.md
# UART receiver with error status

This block receives asynchronous serial frames on a single line and hands each byte to software through a small register bus. The frame is one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A shift register collects the bits. Each bit is sampled at its middle by counting ticks of an external 16x oversampling strobe.

A finished frame moves into a data buffer under three rules. An overrun throws the shifted byte away. A framing or parity error still stores the byte, but the ready flag is not set. A clean frame stores the byte and sets ready.

Software sees four flags in a status register: ready, overrun, framing and parity. The three error flags drive an interrupt request, which is gated by an enable bit. An error flag can be cleared only in two steps: first a status read that saw the flag at 1, then a write of 0 to that bit.

Register map, selected by `addr`:
- Address 0 is the control register: bit 0 parity enable, bit 1 odd parity (0 selects even), bit 2 error interrupt enable.
- Address 1 is the status register: bit 0 ready, bit 1 overrun, bit 2 framing, bit 3 parity.
- Address 2 is the data buffer.

Top module: `uart_rx_stat`

## Requirements
- R1: A frame with a valid stop bit and no parity error loads its eight data bits into the data buffer, LSB first on the line, and sets ready (status bit 0).
- R2: With parity enabled (control bit 0), the received parity bit is checked against the data. Even parity (control bit 1 = 0) expects an even count of ones over data plus parity; odd parity (control bit 1 = 1) expects an odd count. On a mismatch the parity flag (status bit 3) is set, the byte is still loaded, and ready is not set by that frame.
- R3: A stop bit sampled as 0 sets the framing flag (status bit 2), the byte is still loaded, and ready is not set by that frame.
- R4: A frame that ends while ready is 1, with no data read in that same cycle, sets the overrun flag (status bit 1). The data buffer keeps its old byte and ready stays 1.
- R5: When several errors occur on one frame, all of the matching flags are set together.
- R6: `err_irq` is 1 exactly while the interrupt enable (control bit 2) is 1 and at least one error flag is 1.
- R7: An error flag is cleared only by a status read that returned it as 1, followed by a write of 0 to that bit. A write of 0 without such a read leaves the flag unchanged. A write of 1 never sets a flag. An error set in the same cycle as a clearing write wins.
- R8: A read of the data buffer returns the stored byte and clears ready. A data read in the same cycle as a frame completes counts as consuming the old byte: no overrun, the new byte is loaded, and ready is 1.
- R9: A low pulse on the line that has ended before the middle of the start bit is ignored, and no frame is received.
- R10: After reset the control, status and data registers read 0 and `err_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 16x oversampling strobe, one clock wide |
| rxd | input | 1 | Serial receive line, idle high |
| rd | input | 1 | Register read strobe (read side effects) |
| wr | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wdata | input | 4 | Write data (control bits 2:0, status flag bits 3:1) |
| rdata | output | 8 | Read data for the selected register |
| err_irq | output | 1 | Receive-error interrupt request |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the completion of a frame and a bus access to the flags or to the buffer. To provoke it, the bench first measures at the ports the exact cycle in which ready rises for a frame launched at a known tick phase. It then repeats that alignment and places a one-cycle data read, or a clearing status write, in that cycle. The outcome is judged by whether overrun stays clear and the new byte is loaded, or by whether the newly set framing flag survives the clearing write.

The second pair is an error appearing on a frame while ready is still set from an earlier frame. This is judged through the overrun flag and the unchanged buffer.

// File: rtl/uart_rx_stat.sv
module uart_rx_stat #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [3:0]    wdata,
  output logic [DW-1:0] rdata,
  output logic          err_irq
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DW);
  localparam int HALF = OVS / 2 - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t           st;
  logic          rx_m, rx_s;
  logic [CW-1:0] cnt;
  logic [BW-1:0] nbit;
  logic [DW-1:0] sh, buf_q;
  logic          pbit, rdy, f_ovr, f_fe, f_pe;
  logic          par_en, par_odd, err_ie;
  logic [2:0]    armed, clr;

  wire mid     = tick && (cnt == CW'(OVS - 1));
  wire done    = (st == S_STOP) && mid;
  wire fe_now  = !rx_s;
  wire pe_now  = par_en && ((^sh ^ pbit) != par_odd);
  wire dat_rd  = rd && (addr == 2'd2);
  wire st_rd   = rd && (addr == 2'd1);
  wire st_wr   = wr && (addr == 2'd1);
  wire ctl_wr  = wr && (addr == 2'd0);
  wire ovr_now = done && rdy && !dat_rd;

  assign clr     = st_wr ? (armed & ~wdata[3:1]) : 3'b000;
  assign err_irq = err_ie && (f_ovr || f_fe || f_pe);

  always_comb begin
    case (addr)
      2'd0:    rdata = {{(DW-3){1'b0}}, err_ie, par_odd, par_en};
      2'd1:    rdata = {{(DW-4){1'b0}}, f_pe, f_fe, f_ovr, rdy};
      2'd2:    rdata = buf_q;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      st   <= S_IDLE;
      cnt  <= '0;
      nbit <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      case (st)
        S_IDLE:
          if (tick && !rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (tick) begin
            if (cnt == CW'(HALF)) begin
              cnt  <= '0;
              nbit <= '0;
              st   <= rx_s ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        S_HOLD:
          if (rx_s) st <= S_IDLE;
        default: begin
          if (tick) cnt <= mid ? '0 : cnt + 1'b1;
          if (mid) begin
            if (st == S_DATA) begin
              sh   <= {rx_s, sh[DW-1:1]};
              nbit <= nbit + 1'b1;
              if (nbit == BW'(DW - 1)) st <= par_en ? S_PAR : S_STOP;
            end else if (st == S_PAR) begin
              pbit <= rx_s;
              st   <= S_STOP;
            end else begin
              st <= rx_s ? S_IDLE : S_HOLD;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      rdy     <= 1'b0;
      f_ovr   <= 1'b0;
      f_fe    <= 1'b0;
      f_pe    <= 1'b0;
      armed   <= '0;
      par_en  <= 1'b0;
      par_odd <= 1'b0;
      err_ie  <= 1'b0;
    end else begin
      if (ctl_wr) {err_ie, par_odd, par_en} <= wdata[2:0];
      if (done && !ovr_now) buf_q <= sh;
      rdy   <= (done && !ovr_now && !fe_now && !pe_now) || (rdy && !dat_rd);
      f_ovr <= ovr_now || (f_ovr && !clr[0]);
      f_fe  <= (done && fe_now) || (f_fe && !clr[1]);
      f_pe  <= (done && pe_now) || (f_pe && !clr[2]);
      if (st_rd)      armed <= {f_pe, f_fe, f_ovr};
      else if (st_wr) armed <= '0;
      else            armed <= armed & {f_pe, f_fe, f_ovr};
    end
  end

  AST_OVR_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_now |=> $stable(buf_q) && f_ovr && rdy);                              // R4
  AST_ERR_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !rdy && (fe_now || pe_now) |=> !rdy);                             // R2
  AST_FRAME_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done && fe_now |=> f_fe);                                                 // R3
  AST_MULTI_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    done && fe_now && pe_now |=> f_fe && f_pe);                               // R5
  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr && !armed[1] && f_fe |=> f_fe);                                     // R7
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !f_pe |=> !f_pe);                                                // R7
  AST_SAME_CYCLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done && dat_rd && !fe_now && !pe_now |=> rdy && (buf_q == $past(sh)));    // R8
endmodule

// File: tb/sim_uart_rx_stat.sv
module sim_uart_rx_stat;
  logic       clk = 1'b0;
  logic       rst_n, rxd, rd, wr;
  logic [1:0] addr;
  logic [3:0] wdata;
  logic [7:0] rdata;
  logic       err_irq;
  logic [1:0] tc;
  logic       tick;
  int         cyc = 0;
  int         tstart = 1 << 30;
  int         dlat;
  int         nchk = 0;
  int         nerr = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  assign tick = (tc == 2'd0);
  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) tc <= '0;
    else        tc <= tc + 1'b1;
  end

  uart_rx_stat u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rd(rd), .wr(wr),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .err_irq(err_irq));

  // {par_en, odd, flip_parity, stop_bit, data[7:0], expected status[3:0]}
  localparam logic [15:0] VEC [7] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 4'b0001},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 4'b0001},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h01, 4'b0001},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'h7E, 4'b1000},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h80, 4'b1000},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 4'b0100},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 4'b1100}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] val);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 val = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic pen, input logic odd,
                      input logic flip, input logic stop);
    @(negedge clk);
    while (!tick) @(negedge clk);
    tstart = cyc;
    rxd = 1'b0;
    repeat (64) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (64) @(negedge clk);
    end
    if (pen) begin
      rxd = (^b) ^ odd ^ flip;
      repeat (64) @(negedge clk);
    end
    rxd = stop;
    repeat (64) @(negedge clk);
    rxd = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic clear_all();
    bus_rd(2'd2, v);
    bus_rd(2'd1, v);
    bus_wr(2'd1, 4'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    bus_rd(2'd0, v); chk(v, 8'h00, "R10 ctrl");
    bus_rd(2'd1, v); chk(v, 8'h00, "R10 status");
    bus_rd(2'd2, v); chk(v, 8'h00, "R10 data");
    chk({7'd0, err_irq}, 8'h00, "R10 irq");

    // R1 R2 R3 R5 R6 R7: vector table
    foreach (VEC[k]) begin
      bus_wr(2'd0, {1'b0, 1'b1, VEC[k][14], VEC[k][15]});
      send(VEC[k][11:4], VEC[k][15], VEC[k][14], VEC[k][13], VEC[k][12]);
      bus_rd(2'd1, v); chk(v, {4'd0, VEC[k][3:0]}, "R1/R2/R3/R5 status");
      chk({7'd0, err_irq}, {7'd0, |VEC[k][3:1]}, "R6 irq");
      bus_rd(2'd2, v); chk(v, VEC[k][11:4], "R1/R2/R3 data");
      bus_wr(2'd1, 4'h0);
      bus_rd(2'd1, v); chk(v, 8'h00, "R7 cleared");
    end

    // R9: short low glitch ignored
    @(negedge clk); rxd = 1'b0;
    repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (800) @(negedge clk);
    bus_rd(2'd1, v); chk(v, 8'h00, "R9 glitch");

    // R6: interrupt gating
    bus_wr(2'd0, 4'h0);
    send(8'h9A, 1'b0, 1'b0, 1'b0, 1'b0);
    chk({7'd0, err_irq}, 8'h00, "R6 masked");
    bus_wr(2'd0, 4'h4);
    chk({7'd0, err_irq}, 8'h01, "R6 enabled");

    // R7: clear without prior read, write of one
    bus_rd(2'd2, v);
    bus_wr(2'd1, 4'h0);
    bus_rd(2'd1, v); chk(v, 8'h04, "R7 no read first");
    bus_wr(2'd1, 4'hF);
    bus_rd(2'd1, v); chk(v, 8'h04, "R7 write one");
    bus_wr(2'd1, 4'h0);
    bus_rd(2'd1, v); chk(v, 8'h00, "R7 read then zero");
    bus_wr(2'd1, 4'hF);
    bus_rd(2'd1, v); chk(v, 8'h00, "R7 write one never sets");
    bus_wr(2'd0, 4'h0);

    // R4: overrun
    send(8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b0, 1'b0, 1'b1);
    bus_rd(2'd1, v); chk(v, 8'h03, "R4 status");
    bus_rd(2'd2, v); chk(v, 8'h11, "R4 data kept");
    bus_wr(2'd1, 4'h0);

    // calibrate the cycle in which ready rises
    @(negedge clk); addr = 2'd1;
    tstart = 1 << 30;
    fork
      send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
      begin
        do @(negedge clk); while (rdata[0] !== 1'b1);
        dlat = cyc - tstart;
      end
    join
    clear_all();

    // R8: data read in the completion cycle
    send(8'h33, 1'b0, 1'b0, 1'b0, 1'b1);
    tstart = 1 << 30;
    fork
      send(8'h44, 1'b0, 1'b0, 1'b0, 1'b1);
      begin
        do @(negedge clk); while (cyc - tstart != dlat - 1);
        addr = 2'd2; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk); rd = 1'b0;
        chk(v, 8'h33, "R8 old byte returned");
      end
    join
    bus_rd(2'd1, v); chk(v, 8'h01, "R8 no overrun, ready");
    bus_rd(2'd2, v); chk(v, 8'h44, "R8 new byte");
    bus_rd(2'd1, v); chk(v, 8'h00, "R8 read clears ready");

    // R7: set wins over clearing write in the same cycle
    send(8'h0F, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_rd(2'd1, v); chk(v, 8'h04, "R3 framing set");
    tstart = 1 << 30;
    fork
      send(8'hF0, 1'b0, 1'b0, 1'b0, 1'b0);
      begin
        do @(negedge clk); while (cyc - tstart != dlat - 1);
        addr = 2'd1; wdata = 4'h0; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
      end
    join
    bus_rd(2'd1, v); chk(v, 8'h04, "R7 set wins");
    bus_rd(2'd2, v); chk(v, 8'hF0, "R3 data loaded");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule